// File: doc/BRIEF.md
# NAND Spare Buffer Address Mapper

This block turns a linear byte range within the out-of-band (spare) part of a NAND page into a series of address/length bursts aimed at a bank of on-chip spare buffers. Each buffer sits in its own 64-byte window. Software-facing logic gives the block four things: a page-size code, the spare size of the device, a starting byte offset into the spare area and a byte count. The block then produces one burst for each buffer that the range touches.

The spare area is cut into one slice per 512 bytes of page. The slice size is rounded down to an even number of bytes. Any bytes past the last regular slice stay in the final buffer and are not spread further. A request that would reach past the final buffer's 64-byte window is refused with an error flag. A slice size that the windows cannot hold is refused in the same way.

A request is launched with a one-cycle `start`. Bursts leave on a valid/ready handshake. A one-cycle `done`, qualified by `err`, closes every request.

Top module: `nand_spare_mapper`

## Requirements
- R1: The slice size is the spare size shifted right by 0, 2 or 3 bits, with bit 0 then cleared. Page-size code 0 selects 512-byte pages (shift 0), code 1 selects 2048 (shift 2), and code 2 selects 4096 (shift 3).
- R2: The first burst targets buffer index floor(offset / slice), clamped to 7. Its in-buffer offset is offset minus index times slice.
- R3: A burst's address is 0x1000 + index*0x40 + in-buffer offset.
- R4: In buffers 0 to 6 a burst carries min(slice - in-buffer offset, remaining bytes). In buffer 7 it carries all remaining bytes.
- R5: After a burst that leaves bytes remaining, the next burst starts at in-buffer offset 0 of the next buffer. The burst lengths of a request add up to its byte count.
- R6: A request with a byte count of zero raises `done` in the cycle after `start`, with `err` low and no burst.
- R7: Page-size code 3, a slice size of 0, or a slice size above 64 raises `done` and `err` in the cycle after `start`, with no burst.
- R8: If the final buffer's in-buffer offset plus the remaining bytes exceeds 64, the block raises `done` and `err` without sending that burst. Any bursts already sent to earlier buffers stand.
- R9: While `bst_valid_o` is high and `bst_ready_i` is low, the burst address and length hold steady.
- R10: `done` is a one-cycle pulse. It follows the acceptance of the last burst by one cycle. A `start` that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a request (sampled while idle) |
| page_code_i | input | 2 | Page-size code (0: 512, 1: 2048, 2: 4096) |
| spare_size_i | input | 8 | Spare bytes per page |
| offset_i | input | 9 | First spare byte of the range |
| length_i | input | 9 | Bytes in the range |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Last request was refused; valid with done, held until next start |
| bst_valid_o | output | 1 | Burst available |
| bst_ready_i | input | 1 | Burst accepted when high with valid |
| bst_addr_o | output | 13 | Burst start address in the buffer space |
| bst_len_o | output | 7 | Burst length in bytes |

## Verification
Suppose the buffer index or in-buffer offset goes wrong while the block locates the first buffer. The first burst address is then wrong, and this shows on the very first valid cycle. Suppose instead the remaining-byte count or the buffer step goes wrong after a handshake. The next burst then shows a wrong address or length, or the burst count or `done` timing does not match. A wrong slice calculation or a wrong error decision shows either in the cycle after `start`, as a wrong `done`/`err` pair, or as a different burst split. The bench holds `ready` low at random, so stalls that hold or lose a burst are also exposed.

// File: rtl/nsm_pkg.sv
package nsm_pkg;

   typedef enum logic [1:0] {
      NSM_IDLE   = 2'd0,
      NSM_LOCATE = 2'd1,
      NSM_EMIT   = 2'd2
   } nsm_state_e;

   // Right-shift that divides the spare size by the number of 512-byte slices.
   function automatic logic [1:0] page_shift(input logic [1:0] code);
      case (code)
         2'd1:    page_shift = 2'd2;
         2'd2:    page_shift = 2'd3;
         default: page_shift = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/nsm_chunk.sv
module nsm_chunk #(
   parameter int SPARE_W    = 8,
   parameter int WIN_BYTES  = 64,
   parameter bit EVEN_ROUND = 1'b1
) (
   input  logic [1:0]         page_code_i,
   input  logic [SPARE_W-1:0] spare_i,
   output logic [SPARE_W-1:0] chunk_o,
   output logic               cfg_bad_o
);
   localparam int CMP_W = SPARE_W + 1;

   logic [1:0]         shamt;
   logic [SPARE_W-1:0] raw;

   assign shamt = nsm_pkg::page_shift(page_code_i);
   assign raw   = spare_i >> shamt;

   generate
      if (EVEN_ROUND) begin : g_even
         assign chunk_o = {raw[SPARE_W-1:1], 1'b0};
      end else begin : g_exact
         assign chunk_o = raw;
      end
   endgenerate

   assign cfg_bad_o = (page_code_i == 2'd3) || (chunk_o == '0) ||
                      (CMP_W'(chunk_o) > CMP_W'(WIN_BYTES));

   generate
      if (WIN_BYTES >= (1 << CMP_W)) begin : g_bad_win
         $error("nsm_chunk: WIN_BYTES does not fit the comparison width");
      end
   endgenerate
endmodule

// File: rtl/nsm_burst.sv
module nsm_burst #(
   parameter int NUM_BUF   = 8,
   parameter int WIN_BYTES = 64,
   parameter int BASE_ADDR = 'h1000,
   parameter int ADDR_W    = 13,
   parameter int OFF_W     = 9,
   parameter int SPARE_W   = 8,
   localparam int IDX_W    = $clog2(NUM_BUF),
   localparam int WIN_W    = $clog2(WIN_BYTES),
   localparam int LEN_W    = $clog2(WIN_BYTES + 1)
) (
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [OFF_W-1:0]   ofs_i,
   input  logic [OFF_W-1:0]   rem_i,
   input  logic [SPARE_W-1:0] chunk_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [LEN_W-1:0]   len_o,
   output logic               last_o,
   output logic               overrun_o
);
   localparam int XW = OFF_W + 1;

   logic          last_buf;
   logic [XW-1:0] ofs_x, rem_x, chunk_x, win_x, room, take;

   assign last_buf = (idx_i == IDX_W'(NUM_BUF - 1));
   assign ofs_x    = XW'(ofs_i);
   assign rem_x    = XW'(rem_i);
   assign chunk_x  = XW'(chunk_i);
   assign win_x    = XW'(WIN_BYTES);

   // The final buffer absorbs the fold-over up to its window end.
   assign room      = last_buf ? (win_x - ofs_x) : (chunk_x - ofs_x);
   assign overrun_o = last_buf && ((ofs_x + rem_x) > win_x);
   assign take      = (rem_x < room) ? rem_x : room;
   assign len_o     = take[LEN_W-1:0];
   assign last_o    = (take == rem_x);

   assign addr_o = ADDR_W'(BASE_ADDR) + (ADDR_W'(idx_i) << WIN_W) +
                   ADDR_W'(ofs_i[WIN_W-1:0]);
endmodule

// File: rtl/nand_spare_mapper.sv
module nand_spare_mapper #(
   parameter int NUM_BUF    = 8,
   parameter int WIN_BYTES  = 64,
   parameter int BASE_ADDR  = 'h1000,
   parameter int ADDR_W     = 13,
   parameter int OFF_W      = 9,
   parameter int SPARE_W    = 8,
   parameter bit EVEN_ROUND = 1'b1,
   localparam int IDX_W     = $clog2(NUM_BUF),
   localparam int WIN_W     = $clog2(WIN_BYTES),
   localparam int LEN_W     = $clog2(WIN_BYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [1:0]         page_code_i,
   input  logic [SPARE_W-1:0] spare_size_i,
   input  logic [OFF_W-1:0]   offset_i,
   input  logic [OFF_W-1:0]   length_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o,
   output logic               bst_valid_o,
   input  logic               bst_ready_i,
   output logic [ADDR_W-1:0]  bst_addr_o,
   output logic [LEN_W-1:0]   bst_len_o
);
   import nsm_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUF - 1);

   generate
      if ((NUM_BUF & (NUM_BUF - 1)) != 0 || NUM_BUF < 2) begin : g_chk_nbuf
         $error("nand_spare_mapper: NUM_BUF must be a power of two >= 2");
      end
      if ((WIN_BYTES & (WIN_BYTES - 1)) != 0) begin : g_chk_win
         $error("nand_spare_mapper: WIN_BYTES must be a power of two");
      end
      if ((BASE_ADDR % (NUM_BUF * WIN_BYTES)) != 0) begin : g_chk_base
         $error("nand_spare_mapper: BASE_ADDR must align to the buffer bank");
      end
      if (SPARE_W > OFF_W || WIN_W + IDX_W > ADDR_W) begin : g_chk_w
         $error("nand_spare_mapper: inconsistent widths");
      end
   endgenerate

   nsm_state_e         state;
   logic [IDX_W-1:0]   idx_q;
   logic [OFF_W-1:0]   ofs_q, rem_q;
   logic [SPARE_W-1:0] chunk_q, chunk_new;
   logic               cfg_bad, done_q, err_q;
   logic               b_last, b_over;

   nsm_chunk #(
      .SPARE_W   (SPARE_W),
      .WIN_BYTES (WIN_BYTES),
      .EVEN_ROUND(EVEN_ROUND)
   ) u_chunk (
      .page_code_i(page_code_i),
      .spare_i    (spare_size_i),
      .chunk_o    (chunk_new),
      .cfg_bad_o  (cfg_bad)
   );

   nsm_burst #(
      .NUM_BUF  (NUM_BUF),
      .WIN_BYTES(WIN_BYTES),
      .BASE_ADDR(BASE_ADDR),
      .ADDR_W   (ADDR_W),
      .OFF_W    (OFF_W),
      .SPARE_W  (SPARE_W)
   ) u_burst (
      .idx_i    (idx_q),
      .ofs_i    (ofs_q),
      .rem_i    (rem_q),
      .chunk_i  (chunk_q),
      .addr_o   (bst_addr_o),
      .len_o    (bst_len_o),
      .last_o   (b_last),
      .overrun_o(b_over)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= NSM_IDLE;
         idx_q   <= '0;
         ofs_q   <= '0;
         rem_q   <= '0;
         chunk_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            NSM_IDLE: begin
               if (start_i) begin
                  err_q <= 1'b0;
                  if (length_i == '0) begin
                     done_q <= 1'b1;
                  end else if (cfg_bad) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else begin
                     chunk_q <= chunk_new;
                     idx_q   <= '0;
                     ofs_q   <= offset_i;
                     rem_q   <= length_i;
                     state   <= NSM_LOCATE;
                  end
               end
            end
            NSM_LOCATE: begin
               // One subtraction per cycle; stops at the final buffer.
               if (idx_q != LAST_IDX && OFF_W'(chunk_q) <= ofs_q) begin
                  ofs_q <= ofs_q - OFF_W'(chunk_q);
                  idx_q <= idx_q + 1'b1;
               end else begin
                  state <= NSM_EMIT;
               end
            end
            NSM_EMIT: begin
               if (b_over) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  state  <= NSM_IDLE;
               end else if (bst_ready_i) begin
                  if (b_last) begin
                     done_q <= 1'b1;
                     state  <= NSM_IDLE;
                  end else begin
                     rem_q <= rem_q - OFF_W'(bst_len_o);
                     idx_q <= idx_q + 1'b1;
                     ofs_q <= '0;
                  end
               end
            end
            default: state <= NSM_IDLE;
         endcase
      end
   end

   assign busy_o      = (state != NSM_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign bst_valid_o = (state == NSM_EMIT) && !b_over;

   // Emission starts inside the located buffer's slice (except the last one).
   assert_locate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == NSM_EMIT && idx_q != LAST_IDX) |-> (OFF_W'(chunk_q) > ofs_q));

   // A burst never crosses the end of its 64-byte window.
   assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bst_valid_o |-> ((WIN_W + 1)'(bst_addr_o[WIN_W-1:0]) + (WIN_W + 1)'(bst_len_o)
                       <= (WIN_W + 1)'(WIN_BYTES)));

   // Every burst moves at least one byte.
   assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bst_valid_o |-> (bst_len_o != '0));

   // Nothing is offered while idle.
   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !bst_valid_o);

   // An error only appears together with the closing pulse.
   assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> done_o);

   // A stalled burst holds its address and length.
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bst_valid_o && !bst_ready_i) |=>
         (bst_valid_o && $stable(bst_addr_o) && $stable(bst_len_o)));

   // The closing pulse is a single cycle wide.
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: tb/nand_spare_mapper_bench.sv
module nand_spare_mapper_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  page_code_i = '0;
   logic [7:0]  spare_size_i = '0;
   logic [8:0]  offset_i = '0;
   logic [8:0]  length_i = '0;
   logic        bst_ready_i = 1'b0;
   logic        busy_o, done_o, err_o, bst_valid_o;
   logic [12:0] bst_addr_o;
   logic [6:0]  bst_len_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   int exp_n;
   bit exp_err;
   int exp_addr[8];
   int exp_len[8];

   always #4 clk = ~clk;   // 125 MHz

   nand_spare_mapper u_nand_spare_mapper (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_code_i(page_code_i),
      .spare_size_i(spare_size_i), .offset_i(offset_i), .length_i(length_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .bst_valid_o(bst_valid_o),
      .bst_ready_i(bst_ready_i), .bst_addr_o(bst_addr_o), .bst_len_o(bst_len_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected split, from the requirements.
   task automatic model(input int code, input int spare, input int off, input int len);
      int sh, chunk, idx, o, rem, l;
      exp_n = 0;
      exp_err = 0;
      if (len == 0) return;
      sh = (code == 1) ? 2 : (code == 2) ? 3 : 0;
      chunk = (spare >> sh) & ~1;
      if (code == 3 || chunk == 0 || chunk > 64) begin
         exp_err = 1;
         return;
      end
      idx = off / chunk;
      if (idx > 7) idx = 7;
      o = off - idx * chunk;
      rem = len;
      while (rem > 0) begin
         if (idx == 7) begin
            if (o + rem > 64) begin
               exp_err = 1;
               return;
            end
            l = rem;
         end else begin
            l = (chunk - o < rem) ? chunk - o : rem;
         end
         exp_addr[exp_n] = 'h1000 + idx * 'h40 + o;
         exp_len[exp_n]  = l;
         exp_n++;
         rem -= l;
         idx++;
         o = 0;
      end
   endtask

   task automatic run_txn(input int code, input int spare, input int off,
                          input int len, input bit poke);
      int got, c;
      bit fin, pv, pr;
      logic [12:0] pa;
      logic [6:0]  pl;
      model(code, spare, off, len);
      @(negedge clk);
      page_code_i = code[1:0]; spare_size_i = spare[7:0];
      offset_i = off[8:0]; length_i = len[8:0]; start_i = 1'b1;
      bst_ready_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      got = 0; fin = 0; pv = 0; pr = 0; pa = '0; pl = '0;
      for (c = 0; c < 300 && !fin; c++) begin
         if (pv && !pr) begin
            check(bst_valid_o && bst_addr_o == pa && bst_len_o == pl,
                  "R9 stall hold", int'(bst_addr_o), int'(pa));
         end
         if (poke && c == 1) begin
            // Different request while busy: must be ignored (R10).
            page_code_i = 2'd2; spare_size_i = 8'd128; offset_i = 9'd0;
            length_i = 9'd3; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         if (done_o) begin
            fin = 1;
            check(got == exp_n, "R5 R10 burst count at done", got, exp_n);
            check(err_o == exp_err, "R7 R8 err flag", int'(err_o), int'(exp_err));
            check(!bst_valid_o, "R6 no burst with done", int'(bst_valid_o), 0);
            if (len == 0 || exp_err && exp_n == 0 && (code == 3 ||
                ((spare >> ((code == 1) ? 2 : (code == 2) ? 3 : 0)) & ~1) == 0 ||
                ((spare >> ((code == 1) ? 2 : (code == 2) ? 3 : 0)) & ~1) > 64))
               check(c == 0, "R6 R7 done one cycle after start", c, 0);
         end else if (bst_valid_o) begin
            if (got < exp_n) begin
               check(int'(bst_addr_o) == exp_addr[got], "R1 R2 R3 burst address",
                     int'(bst_addr_o), exp_addr[got]);
               check(int'(bst_len_o) == exp_len[got], "R4 R5 burst length",
                     int'(bst_len_o), exp_len[got]);
            end else begin
               check(0, "R5 extra burst", got, exp_n);
            end
         end
         pv = bst_valid_o; pa = bst_addr_o; pl = bst_len_o;
         pr = ($urandom % 4) != 0;
         bst_ready_i = pr;
         if (bst_valid_o && pr && !fin) got++;
         if (!fin) @(negedge clk);
      end
      start_i = 1'b0;
      bst_ready_i = 1'b0;
      if (!fin) check(0, "R10 done never seen", 0, 1);
      @(negedge clk);
      check(!done_o, "R10 done single pulse", int'(done_o), 0);
      check(!busy_o, "R10 idle after request", int'(busy_o), 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      int sp, of, ln, cd, pick;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o && !err_o && !bst_valid_o, "R6 reset state",
            int'({busy_o, done_o, err_o, bst_valid_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o && !bst_valid_o, "R6 idle after reset",
            int'({busy_o, done_o, bst_valid_o}), 0);

      run_txn(1, 64, 10, 30, 0);   // R5 three buffers: 0x100A/6, 0x1040/16, 0x1080/8
      run_txn(2, 218, 200, 18, 0); // R2 clamp to buffer 7, slice 26
      run_txn(0, 16, 5, 11, 0);    // R4 single small-page burst
      run_txn(1, 64, 0, 0, 0);     // R6 zero length
      run_txn(3, 64, 0, 4, 0);     // R7 bad page code
      run_txn(0, 200, 0, 4, 0);    // R7 slice too large
      run_txn(2, 1, 0, 4, 0);      // R7 slice zero
      run_txn(2, 218, 200, 60, 0); // R8 final buffer overrun
      run_txn(2, 218, 0, 218, 0);  // R8 whole spare of 218 with fold-over
      run_txn(1, 64, 10, 30, 1);   // R10 start while busy ignored
      run_txn(2, 128, 127, 1, 0);  // R3 last byte of buffer 7

      for (int i = 0; i < 300; i++) begin
         pick = $urandom % 8;
         cd = (pick == 0) ? 3 : ($urandom % 3);
         case ($urandom % 5)
            0: sp = 16;
            1: sp = 64;
            2: sp = 128;
            3: sp = 218;
            default: sp = $urandom % 256;
         endcase
         of = (sp > 0) ? ($urandom % (sp + 1)) : 0;
         ln = (pick == 1) ? ($urandom % 100) : ((sp - of > 0) ? ($urandom % (sp - of + 1)) : 0);
         run_txn(cd, sp, of, ln, 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule